// File: doc/BRIEF.md
# Priority Interrupt Controller Core

This block collects eight interrupt request lines and forwards at most one of them to a processor through a single interrupt output. A rising edge on a request line latches a pending bit. Each line can be masked. Line 0 ranks highest and line 7 lowest. An in-service register records which interrupts the processor has accepted but not yet finished. A request is forwarded only when it outranks every line that is still in service.

When the processor answers with the acknowledge strobe, the block returns an 8-bit vector on its data output. The vector is a programmed 5-bit base in the upper bits and the winning line number in the lower three. In the same cycle the block moves that line from pending to in service. Software finishes a handler by writing the end-of-interrupt code to the command port. That write retires the highest-ranked in-service line. The mask sits behind a second port. The vector base is loaded through its own configuration strobe.

Top module: `prio_irq_ctrl`

## Requirements
- R1: Among lines that are pending and unmasked, the one with the lowest index wins. Line 0 ranks highest and line 7 lowest.
- R2: A 0-to-1 transition on `req_i[n]` sets pending bit n in the next cycle. A request that stays high does not set the bit again after it has been acknowledged.
- R3: A write with `bus_addr_i`=1 loads the mask register, where bit n masks line n. A read with `bus_addr_i`=1 returns the mask on `data_o`. A masked line never causes `irq_o` to go high.
- R4: `irq_o` is high only when the winning line has a strictly lower index than every set in-service bit, or when no in-service bit is set.
- R5: While `ack_i` is high, `irq_o` is low. If an eligible winner exists, `data_o` = {base[4:0], line[2:0]}. On that edge the winner's pending bit clears and its in-service bit sets.
- R6: A write of 0x20 with `bus_addr_i`=0 clears the lowest-index set in-service bit. Any other value written to that address changes nothing.
- R7: A high `base_we_i` loads `bus_wdata_i[7:3]` as the vector base. With a base of 0x08, lines 0 to 7 return vectors 0x08 to 0x0F.
- R8: `data_o` is zero when `ack_i` is low, except during a read of the mask port.
- R9: Reset clears the pending bits, the in-service bits and the vector base, and sets all mask bits to 1. After reset, `irq_o` is low.
- R10: An acknowledge that arrives with no eligible winner returns {base, 3'b111} and changes neither the pending bits nor the in-service bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 8 | Request lines, edge-detected |
| ack_i | input | 1 | Interrupt acknowledge strobe from the processor |
| bus_we_i | input | 1 | Register write strobe |
| bus_re_i | input | 1 | Register read strobe |
| bus_addr_i | input | 1 | Port select: 0 for command, 1 for mask |
| bus_wdata_i | input | 8 | Register write data |
| base_we_i | input | 1 | Vector base load strobe |
| irq_o | output | 1 | Interrupt request to the processor |
| data_o | output | 8 | Vector during acknowledge, mask on a mask read, otherwise zero |

## Verification
On every cycle the assertions check the following:
- `irq_o` never rises without an unmasked pending line.
- The chosen grant is the lowest-index candidate.
- At most one in-service bit is added per cycle.
- The mask comes out of reset as all ones.
- The data output is zero when it is idle.

Only the bench's scenarios can show the following:
- Nesting: a higher line interrupts a lower one, and an equal or lower line is held back.
- End-of-interrupt retirement in rank order, and the fact that non-matching command values are ignored.
- Vector arithmetic for a programmed base.
- Behaviour of an acknowledge that arrives with nothing to grant.

// File: rtl/irq_pkg.sv
package irq_pkg;
    localparam int NUM_LINES = 8;
    localparam int IDX_W     = $clog2(NUM_LINES);
    localparam int DATA_W    = 8;
    localparam int BASE_W    = DATA_W - IDX_W;
    localparam logic [DATA_W-1:0] EOI_CODE = 8'h20;

    typedef logic [NUM_LINES-1:0] line_vec_t;
    typedef logic [IDX_W-1:0]     line_idx_t;
    typedef logic [BASE_W-1:0]    vec_base_t;

    typedef enum logic {
        PORT_CMD  = 1'b0,
        PORT_MASK = 1'b1
    } port_sel_e;

    typedef struct packed {
        logic      valid;
        line_idx_t idx;
    } grant_t;

    // Lowest set index wins (index 0 is the top rank).
    function automatic grant_t first_set(line_vec_t v);
        grant_t g;
        g.valid = 1'b0;
        g.idx   = '0;
        for (int i = NUM_LINES - 1; i >= 0; i--) begin
            if (v[i]) begin
                g.valid = 1'b1;
                g.idx   = line_idx_t'(i);
            end
        end
        return g;
    endfunction
endpackage

// File: rtl/irq_req_capture.sv
module irq_req_capture
    import irq_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  line_vec_t req_i,
    input  line_vec_t clr_i,
    output line_vec_t pend_o
);
    line_vec_t req_q;
    line_vec_t pend_q;

    for (genvar n = 0; n < NUM_LINES; n++) begin : g_line
        logic rise;
        assign rise = req_i[n] & ~req_q[n];
        always_ff @(posedge clk) begin
            if (rst) begin
                req_q[n]  <= 1'b0;
                pend_q[n] <= 1'b0;
            end else begin
                req_q[n]  <= req_i[n];
                pend_q[n] <= (pend_q[n] & ~clr_i[n]) | rise;
            end
        end
    end

    assign pend_o = pend_q;

    AST_PEND_NEEDS_EDGE: assert property (@(posedge clk) disable iff (rst)
        (!$past(pend_q[0]) && pend_q[0]) |-> ($past(req_i[0]) && !$past(req_q[0]))) else $error("pending without edge"); // R2
endmodule

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs
    import irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              mask_we_i,
    input  logic              base_we_i,
    input  logic [DATA_W-1:0] wdata_i,
    output line_vec_t         mask_o,
    output vec_base_t         base_o
);
    line_vec_t mask_q;
    vec_base_t base_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= '1;
            base_q <= '0;
        end else begin
            if (mask_we_i) mask_q <= wdata_i[NUM_LINES-1:0];
            if (base_we_i) base_q <= wdata_i[DATA_W-1:IDX_W];
        end
    end

    assign mask_o = mask_q;
    assign base_o = base_q;

    AST_MASK_RESET_ALL: assert property (@(posedge clk)
        ($past(rst) && !rst) |-> (mask_q == '1)) else $error("mask not all ones after reset"); // R9
endmodule

// File: rtl/irq_inservice.sv
module irq_inservice
    import irq_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      set_i,
    input  line_idx_t set_idx_i,
    input  logic      eoi_i,
    output line_vec_t isr_o,
    output grant_t    top_o
);
    line_vec_t isr_q;
    line_vec_t set_vec;
    line_vec_t clr_vec;
    grant_t    top;

    assign top = first_set(isr_q);

    always_comb begin
        set_vec = '0;
        clr_vec = '0;
        if (set_i) set_vec[set_idx_i] = 1'b1;
        if (eoi_i && top.valid) clr_vec[top.idx] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) isr_q <= '0;
        else     isr_q <= (isr_q & ~clr_vec) | set_vec;
    end

    assign isr_o = isr_q;
    assign top_o = top;

    AST_ISR_GROW_ONE: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> ($countones(isr_q) <= $countones($past(isr_q)) + 1)) else $error("isr grew by more than one"); // R5
endmodule

// File: rtl/irq_prio_resolve.sv
module irq_prio_resolve
    import irq_pkg::*;
(
    input  line_vec_t pend_i,
    input  line_vec_t mask_i,
    input  grant_t    isr_top_i,
    output grant_t    cand_o,
    output logic      eligible_o
);
    line_vec_t live;
    grant_t    cand;

    assign live = pend_i & ~mask_i;
    assign cand = first_set(live);

    assign cand_o     = cand;
    assign eligible_o = cand.valid && (!isr_top_i.valid || (cand.idx < isr_top_i.idx));
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
    import irq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [7:0] req_i,
    input  logic       ack_i,
    input  logic       bus_we_i,
    input  logic       bus_re_i,
    input  logic       bus_addr_i,
    input  logic [7:0] bus_wdata_i,
    input  logic       base_we_i,
    output logic       irq_o,
    output logic [7:0] data_o
);
    line_vec_t pend;
    line_vec_t mask;
    line_vec_t isr;
    line_vec_t ack_clr;
    vec_base_t base;
    grant_t    cand;
    grant_t    isr_top;
    logic      eligible;
    logic      grant_fire;
    logic      eoi_wr;
    logic      mask_wr;
    port_sel_e port;
    line_idx_t ack_idx;

    assign port       = port_sel_e'(bus_addr_i);
    assign mask_wr    = bus_we_i && (port == PORT_MASK);
    assign eoi_wr     = bus_we_i && (port == PORT_CMD) && (bus_wdata_i == EOI_CODE);
    assign grant_fire = ack_i && eligible;

    always_comb begin
        ack_clr = '0;
        if (grant_fire) ack_clr[cand.idx] = 1'b1;
    end

    irq_req_capture u_capture (
        .clk    (clk),
        .rst    (rst),
        .req_i  (req_i),
        .clr_i  (ack_clr),
        .pend_o (pend)
    );

    irq_cfg_regs u_cfg (
        .clk       (clk),
        .rst       (rst),
        .mask_we_i (mask_wr),
        .base_we_i (base_we_i),
        .wdata_i   (bus_wdata_i),
        .mask_o    (mask),
        .base_o    (base)
    );

    irq_inservice u_isr (
        .clk       (clk),
        .rst       (rst),
        .set_i     (grant_fire),
        .set_idx_i (cand.idx),
        .eoi_i     (eoi_wr),
        .isr_o     (isr),
        .top_o     (isr_top)
    );

    irq_prio_resolve u_resolve (
        .pend_i     (pend),
        .mask_i     (mask),
        .isr_top_i  (isr_top),
        .cand_o     (cand),
        .eligible_o (eligible)
    );

    assign ack_idx = grant_fire ? cand.idx : line_idx_t'(NUM_LINES - 1);
    assign irq_o   = eligible && !ack_i;

    always_comb begin
        if (ack_i)                            data_o = {base, ack_idx};
        else if (bus_re_i && port == PORT_MASK) data_o = mask;
        else                                  data_o = '0;
    end

    AST_IRQ_UNMASKED: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> ((pend & ~mask) != '0)) else $error("irq with no live line"); // R3
    AST_GRANT_IS_LOWEST: assert property (@(posedge clk) disable iff (rst)
        cand.valid |-> (pend[cand.idx] && !mask[cand.idx] &&
                        ((pend & ~mask & ((line_vec_t'(1) << cand.idx) - 1'b1)) == '0))) else $error("grant not top rank"); // R1
    AST_IRQ_OUTRANKS_ISR: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> ((isr & ((line_vec_t'(1) << (cand.idx + 1'b1)) - 1'b1)) == '0 || cand.idx == line_idx_t'(NUM_LINES-1) && isr == '0)) else $error("irq while blocked"); // R4
    AST_DATA_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
        (!ack_i && !bus_re_i) |-> (data_o == '0)) else $error("data not idle"); // R8
endmodule

// File: tb/prio_irq_ctrl_tb.sv
module prio_irq_ctrl_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] req_i = '0;
    logic       ack_i = 1'b0;
    logic       bus_we_i = 1'b0;
    logic       bus_re_i = 1'b0;
    logic       bus_addr_i = 1'b0;
    logic [7:0] bus_wdata_i = '0;
    logic       base_we_i = 1'b0;
    logic       irq_o;
    logic [7:0] data_o;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    logic [7:0] m_pend, m_isr, m_mask, m_prev;
    logic [4:0] m_base;

    always #10 clk = ~clk;

    prio_irq_ctrl u_dut (
        .clk(clk), .rst(rst), .req_i(req_i), .ack_i(ack_i),
        .bus_we_i(bus_we_i), .bus_re_i(bus_re_i), .bus_addr_i(bus_addr_i),
        .bus_wdata_i(bus_wdata_i), .base_we_i(base_we_i),
        .irq_o(irq_o), .data_o(data_o)
    );

    function automatic int low_idx(logic [7:0] v);
        for (int i = 0; i < 8; i++) if (v[i]) return i;
        return 8;
    endfunction

    function automatic int win_idx();
        int c = low_idx(m_pend & ~m_mask);
        if (c < 8 && c < low_idx(m_isr)) return c;
        return 8;
    endfunction

    function automatic logic exp_irq();
        return (win_idx() < 8) && !ack_i;
    endfunction

    function automatic logic [7:0] exp_data();
        int w = win_idx();
        if (ack_i) return {m_base, (w < 8) ? 3'(w) : 3'd7};
        if (bus_re_i && bus_addr_i) return m_mask;
        return 8'h00;
    endfunction

    task automatic check(input logic ok, input string tag, input string what,
                         input logic [7:0] act, input logic [7:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%02h expected=%02h", tag, what, act, exp);
        end
    endtask

    task automatic model_reset();
        m_pend = '0; m_isr = '0; m_mask = 8'hFF; m_prev = '0; m_base = '0;
    endtask

    task automatic model_edge();
        int w = win_idx();
        int t = low_idx(m_isr);
        logic [7:0] np = m_pend;
        logic [7:0] ni = m_isr;
        if (ack_i && w < 8) begin np[w] = 1'b0; ni[w] = 1'b1; end
        if (bus_we_i && !bus_addr_i && bus_wdata_i == 8'h20 && t < 8) ni[t] = 1'b0;
        if (bus_we_i && bus_addr_i) m_mask = bus_wdata_i;
        if (base_we_i) m_base = bus_wdata_i[7:3];
        m_pend = np | (req_i & ~m_prev);
        m_isr  = ni;
        m_prev = req_i;
    endtask

    task automatic step(input logic [7:0] rq, input logic ak, input logic we,
                        input logic re, input logic ad, input logic [7:0] wd,
                        input logic bwe, input string tag);
        logic ei;
        logic [7:0] ed;
        req_i = rq; ack_i = ak; bus_we_i = we; bus_re_i = re;
        bus_addr_i = ad; bus_wdata_i = wd; base_we_i = bwe;
        #2;
        ei = exp_irq();
        ed = exp_data();
        check(irq_o === ei, tag, "irq_o", {7'd0, irq_o}, {7'd0, ei});
        check(data_o === ed, tag, "data_o", data_o, ed);
        @(posedge clk);
        model_edge();
        @(negedge clk);
    endtask

    task automatic idle(input logic [7:0] rq, input string tag);
        step(rq, 0, 0, 0, 0, 8'h00, 0, tag);
    endtask

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R9: reset state, mask reads all ones
        step(8'h00, 0, 0, 1, 1, 8'h00, 0, "R9");
        step(8'h00, 0, 0, 0, 0, 8'h00, 0, "R9");
        // R7: base 0x08
        step(8'h00, 0, 0, 0, 0, 8'h08, 1, "R7");
        // R3: open all lines, read back
        step(8'h00, 0, 1, 0, 1, 8'h00, 0, "R3");
        step(8'h00, 0, 0, 1, 1, 8'h00, 0, "R3");
        // R2: edge on line 5, held high
        idle(8'h20, "R2");
        idle(8'h20, "R2");
        step(8'h20, 1, 0, 0, 0, 8'h00, 0, "R5");
        idle(8'h20, "R2");
        idle(8'h20, "R2");
        step(8'h00, 0, 1, 0, 0, 8'h20, 0, "R6");
        idle(8'h00, "R2");
        // R3: mask line 3, raise it
        step(8'h00, 0, 1, 0, 1, 8'h08, 0, "R3");
        idle(8'h08, "R3");
        idle(8'h08, "R3");
        step(8'h00, 0, 1, 0, 1, 8'h00, 0, "R3");
        idle(8'h00, "R3");
        step(8'h00, 1, 0, 0, 0, 8'h00, 0, "R5");
        step(8'h00, 0, 1, 0, 0, 8'h20, 0, "R6");
        // R1: lines 6 and 2 together
        idle(8'h44, "R1");
        step(8'h00, 1, 0, 0, 0, 8'h00, 0, "R1");
        // R4: line 4 blocked, line 6 blocked, line 1 nests
        idle(8'h10, "R4");
        idle(8'h00, "R4");
        idle(8'h02, "R4");
        step(8'h00, 1, 0, 0, 0, 8'h00, 0, "R4");
        idle(8'h00, "R4");
        // R6: non-matching command ignored
        step(8'h00, 0, 1, 0, 0, 8'h21, 0, "R6");
        idle(8'h00, "R6");
        step(8'h00, 0, 1, 0, 0, 8'h20, 0, "R6");
        idle(8'h00, "R6");
        step(8'h00, 0, 1, 0, 0, 8'h20, 0, "R6");
        step(8'h00, 1, 0, 0, 0, 8'h00, 0, "R5");
        step(8'h00, 0, 1, 0, 0, 8'h20, 0, "R6");
        // R7: base 0x70
        step(8'h00, 0, 0, 0, 0, 8'h70, 1, "R7");
        step(8'h00, 1, 0, 0, 0, 8'h00, 0, "R7");
        step(8'h00, 0, 1, 0, 0, 8'h20, 0, "R6");
        step(8'h00, 0, 1, 0, 0, 8'h20, 0, "R6");
        // R10: acknowledge with nothing eligible
        step(8'h00, 1, 0, 0, 0, 8'h00, 0, "R10");
        idle(8'h00, "R10");
        // R8: idle data and command read
        step(8'h00, 0, 0, 1, 0, 8'h00, 0, "R8");
        // random phase
        void'($urandom(32'h1D5E_7A11));
        for (int k = 0; k < 3000; k++) begin
            logic [7:0] rq;
            logic ak, we, re, ad, bw;
            logic [7:0] wd;
            int sel;
            rq = req_i;
            for (int b = 0; b < 8; b++) if ($urandom_range(0, 9) == 0) rq[b] = ~rq[b];
            ak = irq_o ? ($urandom_range(0, 2) == 0) : ($urandom_range(0, 40) == 0);
            sel = $urandom_range(0, 19);
            we = (sel < 5); re = (sel >= 5 && sel < 8); bw = (sel == 19);
            ad = (sel == 4) || (sel == 5);
            wd = (sel < 3) ? 8'h20 : 8'($urandom_range(0, 255));
            if (sel == 4) wd = wd & 8'h3C;
            step(rq, ak, we, re, ad, wd, bw, ak ? "R5" : "R4");
        end
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule